// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block is a word-addressed general-purpose I/O controller for a parameterised number of pins (twelve by default). Software drives each pin through an output latch and a direction bit, and reads the pins back through a two-flop synchronizer. Each pin also has an interrupt detector that can be set to trigger on a rising edge, a falling edge, either edge, a high level or a low level.

Detected events set a per-pin pending bit, but only when that pin's enable bit is set. A mask register is changed only through two write-one words, one that sets mask bits and one that clears them. Pending bits are also cleared by writing ones. A single interrupt line is the OR of every pin whose bit is pending, enabled and unmasked. A software reset word holds all configuration and pending state at its defaults for as long as its bit 0 stays 1.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, enable, pending status, direction, output data and all mode fields read 0, the mask reads all ones in its low 12 bits, and `irq` is 0.
- R2: `pin_oe` equals the direction word (word 8, 1 = output) and `pin_out` equals the output data word (word 6), and both read back what was written.
- R3: The input word (word 7) returns the pin levels through a two-flop synchronizer, so a level on `pin_in` shows up within three clock edges.
- R4: Each pin has a 3-bit mode in a 4-bit nibble: pins 0 to 7 sit in word 9 at bit 4×pin, and pins 8 to 11 sit in word 10 at bit 4×(pin−8). Bit 3 of each nibble, and any nibble with no pin, reads 0.
- R5: Mode 1 sets a pin's status on a rising edge, mode 0 on a falling edge and mode 4 on either edge. Modes 5 to 7 never set status.
- R6: Mode 3 (level high) and mode 2 (level low) set status on every cycle the level holds, so a clear written while the level persists leaves the bit set.
- R7: A pin's status bit is set only while its enable bit (word 0) is 1.
- R8: Writing ones to word 3 clears those status bits (word 1). Zero bits leave status unchanged.
- R9: Writing ones to word 4 sets mask bits and writing ones to word 5 clears them. Zero bits have no effect. Both words read back the mask.
- R10: `irq` is the OR of status AND enable AND NOT mask. Word 2 shows that same vector, and word 1 shows pending bits whatever the mask.
- R11: While bit 0 of word 15 is 1, all other registers are held at their R1 defaults and writes to them are ignored. Writing 0 there releases them, and word 15 reads back its bit.
- R12: Only the low 12 bits of the enable, status, mask, direction, output and input words are stored or returned. Higher bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 4 | Word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the word at `addr` (combinational) |
| pin_in | input | 12 | Pin levels, asynchronous |
| pin_out | output | 12 | Output data latch |
| pin_oe | output | 12 | Output enable, one bit per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
A detector left in the wrong state shows up on the status word three or four edges after a pin change. A missed edge, or an edge that was not there, then leaves a status bit that disagrees with the selected mode. A wrong mask or enable bit appears at once on `irq` and on word 2, because both follow the registers combinationally. A wrong soft-reset hold appears on the next read of any configuration word, which comes back nonzero or accepts a write that should have been ignored.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [2:0] {
    TRIG_FALL = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_LOW  = 3'd2,
    TRIG_HIGH = 3'd3,
    TRIG_BOTH = 3'd4
  } trig_t;

  localparam int IDX_EN    = 0;
  localparam int IDX_STAT  = 1;
  localparam int IDX_SHOW  = 2;
  localparam int IDX_CLR   = 3;
  localparam int IDX_MSET  = 4;
  localparam int IDX_MCLR  = 5;
  localparam int IDX_OUT   = 6;
  localparam int IDX_IN    = 7;
  localparam int IDX_DIR   = 8;
  localparam int IDX_MODE0 = 9;
  localparam int IDX_RST   = 15;

  localparam int PINS_PER_WORD = 8;

  function automatic int mode_word(input int pin);
    return pin / PINS_PER_WORD;
  endfunction

  function automatic int mode_lsb(input int pin);
    return 4 * (pin % PINS_PER_WORD);
  endfunction

  function automatic logic trig_hit(input logic [2:0] mode, input logic cur, input logic prev);
    case (mode)
      TRIG_FALL: return prev & ~cur;
      TRIG_RISE: return cur & ~prev;
      TRIG_LOW:  return ~cur;
      TRIG_HIGH: return cur;
      TRIG_BOTH: return cur ^ prev;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       cur,
  input  logic [2:0] mode,
  input  logic       en,
  input  logic       clr,
  output logic       hit,
  output logic       st
);
  logic prev_q;

  assign hit = trig_hit(mode, cur, prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        st <= 1'b0;
    else if (soft_rst) st <= 1'b0;
    else               st <= (st & ~clr) | (hit & en);
  end

  // R7: a disabled pin never raises its pending bit
  p_no_set_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !st) |=> !st);

  // R8: a clear with no new event leaves the bit low
  p_clear_takes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !st);

  // R6: a held high level keeps the bit set
  p_level_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !soft_rst && mode == TRIG_HIGH && cur) |=> st);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 12,
  parameter int AW    = 4,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  localparam int MODE_WORDS = (NPINS + PINS_PER_WORD - 1) / PINS_PER_WORD;

  logic             rst_q, soft_rst;
  logic [NPINS-1:0] en_q, mask_q, out_q, dir_q;
  logic [NPINS-1:0] sync_vec, hit_vec, st_vec, clr_vec, show_vec;
  logic [2:0]       mode_q [NPINS];
  logic [DW-1:0]    mode_rd [MODE_WORDS];
  logic             wr_en_w, wr_clr, wr_mset, wr_mclr, wr_out, wr_dir, wr_rst;
  logic             unused_wbits;

  assign unused_wbits = ^wdata;

  assign wr_en_w = wr_en && addr == AW'(IDX_EN);
  assign wr_clr  = wr_en && addr == AW'(IDX_CLR);
  assign wr_mset = wr_en && addr == AW'(IDX_MSET);
  assign wr_mclr = wr_en && addr == AW'(IDX_MCLR);
  assign wr_out  = wr_en && addr == AW'(IDX_OUT);
  assign wr_dir  = wr_en && addr == AW'(IDX_DIR);
  assign wr_rst  = wr_en && addr == AW'(IDX_RST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rst_q <= 1'b0;
    else if (wr_rst) rst_q <= wdata[0];
  end
  assign soft_rst = rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_rst) begin
      en_q   <= '0;
      mask_q <= '1;
      out_q  <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_en_w) en_q  <= wdata[NPINS-1:0];
      if (wr_out)  out_q <= wdata[NPINS-1:0];
      if (wr_dir)  dir_q <= wdata[NPINS-1:0];
      if (wr_mset) mask_q <= mask_q | wdata[NPINS-1:0];
      else if (wr_mclr) mask_q <= mask_q & ~wdata[NPINS-1:0];
    end
  end

  gpio_pin_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_vec)
  );

  assign clr_vec = wr_clr ? wdata[NPINS-1:0] : '0;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int MW  = mode_word(p);
    localparam int LSB = mode_lsb(p);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || soft_rst) mode_q[p] <= TRIG_FALL;
      else if (wr_en && addr == AW'(IDX_MODE0 + MW)) mode_q[p] <= wdata[LSB +: 3];
    end

    gpio_irq_detect u_det (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cur(sync_vec[p]),
      .mode(mode_q[p]), .en(en_q[p]), .clr(clr_vec[p]),
      .hit(hit_vec[p]), .st(st_vec[p])
    );
  end

  always_comb begin
    for (int w = 0; w < MODE_WORDS; w++) mode_rd[w] = '0;
    for (int p = 0; p < NPINS; p++) mode_rd[mode_word(p)][mode_lsb(p) +: 3] = mode_q[p];
  end

  assign show_vec = st_vec & en_q & ~mask_q;
  assign irq      = |show_vec;
  assign pin_out  = out_q;
  assign pin_oe   = dir_q;

  always_comb begin
    rdata = '0;
    case (int'(addr))
      IDX_EN:             rdata[NPINS-1:0] = en_q;
      IDX_STAT:           rdata[NPINS-1:0] = st_vec;
      IDX_SHOW:           rdata[NPINS-1:0] = show_vec;
      IDX_MSET, IDX_MCLR: rdata[NPINS-1:0] = mask_q;
      IDX_OUT:            rdata[NPINS-1:0] = out_q;
      IDX_IN:             rdata[NPINS-1:0] = sync_vec;
      IDX_DIR:            rdata[NPINS-1:0] = dir_q;
      IDX_RST:            rdata[0]         = rst_q;
      default: begin
        for (int w = 0; w < MODE_WORDS; w++)
          if (int'(addr) == IDX_MODE0 + w) rdata = mode_rd[w];
      end
    endcase
  end

  // R11: the soft reset word forces defaults on the next edge
  p_softrst_defaults_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (mask_q == '1 && en_q == '0 && dir_q == '0 && out_q == '0));

  // R9: a mask-set write leaves every written bit set
  p_mask_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mset && !soft_rst) |=> ((mask_q & $past(wdata[NPINS-1:0])) == $past(wdata[NPINS-1:0])));

  // R10: a fully masked block keeps its request low
  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !irq);

  // R7: a fully disabled block keeps its request low
  p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
endmodule

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [11:0] pin_in = '0;
  logic [11:0] pin_out, pin_oe;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  event        smp_ev;

  always #5 clk = ~clk;

  gpio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    -> smp_ev;
    #2;
  endtask

  task automatic sig_chk(input logic [31:0] act, input logic [31:0] e, input string t);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", t, act, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    forever begin
      logic [31:0] e;
      string t;
      @(smp_ev);
      #1;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", t, rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-reqs actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    rd_chk(0, 32'h0, "R1 enable");
    rd_chk(1, 32'h0, "R1 status");
    rd_chk(4, 32'h0000_0FFF, "R1 mask");
    rd_chk(8, 32'h0, "R1 dir");
    rd_chk(9, 32'h0, "R1 mode0");
    sig_chk({31'b0, irq}, 0, "R1 irq");

    // R2 / R12 output and direction
    wr(6, 32'hFFFF_FA5A);
    wr(8, 32'h0000_00F0);
    sig_chk({20'b0, pin_out}, 32'hA5A, "R2 pin_out");
    sig_chk({20'b0, pin_oe}, 32'h0F0, "R2 pin_oe");
    rd_chk(6, 32'h0000_0A5A, "R12 out upper bits");
    rd_chk(8, 32'h0000_00F0, "R2 dir readback");

    // R3 input path
    pin_in = 12'h3C5;
    idle(3);
    rd_chk(7, 32'h0000_03C5, "R3 input word");
    pin_in = 12'h000;
    idle(3);
    rd_chk(7, 32'h0, "R3 input low");

    // R4 mode layout
    wr(9, 32'hFFFF_FFFF);
    wr(10, 32'hFFFF_FFFF);
    rd_chk(9, 32'h7777_7777, "R4 mode0 nibbles");
    rd_chk(10, 32'h0000_7777, "R4 mode1 nibbles");
    wr(9, 32'h1152_3401);
    wr(10, 32'h0000_1111);
    rd_chk(9, 32'h1152_3401, "R4 mode0 readback");

    // R7 disabled pins do not record
    pin_in = 12'h001; idle(4);
    pin_in = 12'h000; idle(4);
    rd_chk(1, 32'h0, "R7 disabled status");

    // R5 edge modes
    wr(0, 32'h0000_0027);
    pin_in = 12'h027; idle(5);
    rd_chk(1, 32'h0000_0005, "R5 rising and both");
    sig_chk({31'b0, irq}, 0, "R10 masked irq");
    wr(3, 32'h0000_0FFF);
    rd_chk(1, 32'h0, "R8 clear all");
    pin_in = 12'h000; idle(5);
    rd_chk(1, 32'h0000_0006, "R5 falling and both");

    // R8 partial clear
    wr(3, 32'h0000_0002);
    rd_chk(1, 32'h0000_0004, "R8 partial clear");
    wr(3, 32'h0000_0004);
    rd_chk(1, 32'h0, "R8 clear rest");

    // R6 level modes
    wr(0, 32'h0000_0018);
    idle(2);
    rd_chk(1, 32'h0000_0010, "R6 level low sets");
    wr(3, 32'h0000_0010);
    rd_chk(1, 32'h0000_0010, "R6 level re-sets after clear");
    sig_chk({31'b0, irq}, 0, "R10 status visible while masked");

    // R9 / R10 mask words
    wr(5, 32'h0000_0010);
    rd_chk(4, 32'h0000_0FEF, "R9 mask clear");
    sig_chk({31'b0, irq}, 1, "R10 irq unmasked");
    rd_chk(2, 32'h0000_0010, "R10 shown vector");
    wr(4, 32'h0);
    rd_chk(5, 32'h0000_0FEF, "R9 zero write no effect");
    wr(4, 32'h0000_0010);
    rd_chk(4, 32'h0000_0FFF, "R9 mask set");
    sig_chk({31'b0, irq}, 0, "R10 irq masked again");

    pin_in = 12'h008; idle(5);
    rd_chk(1, 32'h0000_0018, "R6 level high sets");
    pin_in = 12'h010; idle(5);
    wr(3, 32'h0000_0018);
    rd_chk(1, 32'h0, "R6 cleared once level gone");

    // R11 soft reset
    wr(5, 32'h0000_0001);
    wr(15, 32'h1);
    rd_chk(15, 32'h1, "R11 reset word");
    rd_chk(8, 32'h0, "R11 dir default");
    rd_chk(4, 32'h0000_0FFF, "R11 mask default");
    rd_chk(0, 32'h0, "R11 enable default");
    sig_chk({20'b0, pin_out}, 0, "R11 pin_out default");
    wr(8, 32'h0000_0FFF);
    rd_chk(8, 32'h0, "R11 write ignored");
    wr(15, 32'h0);
    rd_chk(15, 32'h0, "R11 reset released");
    wr(8, 32'h0000_000F);
    rd_chk(8, 32'h0000_000F, "R11 writes accepted");

    // R12 upper bits
    wr(0, 32'hFFFF_FFFF);
    rd_chk(0, 32'h0000_0FFF, "R12 enable width");

    idle(2);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule